// File: doc/BRIEF.md
# Linked Command List Processor

This block is the command engine of a controller that keeps its work as a chain of control blocks in system memory. Software loads a base address and then issues a start command carrying the offset of the first block. The engine fetches each block header over a single memory port and lets the per-command action run. Every command action is modelled here as a fixed delay. The engine then marks the block finished in memory and follows the block's link to the next one. Per-block flags tell it to raise an interrupt, to pause in a suspended state, or to stop at the end of the chain.

A paused chain is continued with a resume command. The engine first reads the header of the block it paused on. It only moves on once software has cleared that block's suspend flag, and it then continues from the link it saved when it paused. The engine also keeps two event counters. It can copy them to a statistics area in memory, with or without clearing them afterwards.

Commands enter through a one-entry holding slot. A command that arrives while a chain is being walked waits there until the engine is back in idle, suspended or parked.

Top module: `cmdlist_walker`

## Requirements
- R1: After reset the engine reports idle (cu_state 0), raises no memory request and no interrupt, and can accept a command (cmd_ready high).
- R2: A start command (op 1) is taken only when cu_state is idle (0) or suspended (1). It loads the current offset from cmd_ptr and sets cu_state to active (2). In the active state a start causes no memory access and no state change.
- R3: A block at offset O is fetched as two 32-bit reads, at base+O and base+O+4. Header word bit 31 is end-of-list, bit 30 is suspend and bit 29 is interrupt. The second word is the link offset. The block then executes for EXEC_LAT cycles. A request held while mem_req_ready is low keeps its address and direction.
- R4: The status write-back is one write to base+O with byte enables 0011. Its data is the header word with bit 15 (complete) and bit 13 (ok) set, so the upper 16 bits in memory are left as they were.
- R5: irq_done is a one-cycle pulse that follows the accepted write-back of a block whose interrupt bit is set.
- R6: Suspend is tested before end-of-list. A block with suspend set puts the engine in suspended (1) and saves its link as the resume offset. irq_notactive pulses only if the block's interrupt bit is set and cfg_idle_mode is 0.
- R7: A block with end-of-list set and suspend clear returns the engine to idle (0). irq_notactive pulses if the interrupt bit is set, whatever cfg_idle_mode is.
- R8: A block with neither flag makes the engine fetch the next block at base plus that block's link offset.
- R9: Resume (op 2) reads only the header word of the current block. If its suspend bit is still set, nothing else happens. Otherwise cu_state becomes active. If that header also has end-of-list set, the engine parks in active and makes no further access. If not, it continues at the saved resume offset.
- R10: Load-base (op 6) and load-statistics-address (op 4) copy cmd_ptr into the base and statistics address registers.
- R11: Dump (op 5) writes the counters as full words at stats, stats+4, and so on: counter 0 counts completed blocks and counter 1 counts suspensions. It then writes the mark 0x0000A005 after the last counter. Dump-and-clear (op 7) writes the mark 0x0000A007 instead and then zeroes every counter.
- R12: While a chain is being walked, a newly accepted command is held (cmd_ready low). It is carried out only after the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idle_mode | input | 1 | 1 selects command-idle interrupt mode (no not-active interrupt on suspend) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Holding slot is empty |
| cmd_op | input | 4 | Command code |
| cmd_ptr | input | ADDR_W | Pointer value carried with the command |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for write |
| mem_req_be | output | 4 | Byte enables for writes |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the outstanding request (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |
| irq_done | output | 1 | Block-complete interrupt pulse |
| irq_notactive | output | 1 | Not-active interrupt pulse |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |

## Verification
The bench targets a few corner cases.

- **Flag precedence.** A block carries both suspend and end-of-list. A design that tests end-of-list first would go idle instead of suspended.
- **Resume gating.** Resume is issued while the paused block still has its suspend bit set. A design that skips the re-read would walk on, and the scoreboard would see a write it did not expect.
- **Interrupt mode.** Suspend is exercised in both interrupt modes. This catches a not-active pulse that ignores the mode, and also one that is wrongly suppressed at end-of-list.
- **Parked state and command holding.** The parked active state must refuse a start. A dump issued during a walk must appear in the write stream only after the walk's last status write; a design that runs commands early would interleave them.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;

   typedef enum logic [1:0] {
      CU_IDLE   = 2'd0,
      CU_SUSP   = 2'd1,
      CU_ACTIVE = 2'd2
   } cu_state_e;

   typedef enum logic [3:0] {
      PH_WAIT,
      PH_RD0_REQ, PH_RD0_RSP,
      PH_RD1_REQ, PH_RD1_RSP,
      PH_EXEC,
      PH_WB_REQ,  PH_WB_RSP,
      PH_RSM_REQ, PH_RSM_RSP,
      PH_DMP_REQ, PH_DMP_RSP
   } phase_e;

   localparam logic [3:0] OP_START    = 4'd1;
   localparam logic [3:0] OP_RESUME   = 4'd2;
   localparam logic [3:0] OP_LD_STATS = 4'd4;
   localparam logic [3:0] OP_DUMP     = 4'd5;
   localparam logic [3:0] OP_LD_BASE  = 4'd6;
   localparam logic [3:0] OP_DUMP_CLR = 4'd7;

   localparam int HDR_EL   = 31;
   localparam int HDR_SUSP = 30;
   localparam int HDR_IRQ  = 29;

   localparam logic [31:0] WB_FLAGS      = 32'h0000_A000;
   localparam logic [31:0] MARK_DUMP     = 32'h0000_A005;
   localparam logic [31:0] MARK_DUMP_CLR = 32'h0000_A007;
   localparam logic [3:0]  BE_STATUS     = 4'b0011;

endpackage

// File: rtl/cmdlist_cmd_slot.sv
module cmdlist_cmd_slot #(
   parameter int PTR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [3:0]       in_op,
   input  logic [PTR_W-1:0] in_ptr,
   input  logic             take,
   output logic             full,
   output logic [3:0]       op,
   output logic [PTR_W-1:0] ptr
);

   assign in_ready = ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         op   <= '0;
         ptr  <= '0;
      end else if (full && take) begin
         full <= 1'b0;
      end else if (in_valid && !full) begin
         full <= 1'b1;
         op   <= in_op;
         ptr  <= in_ptr;
      end
   end

   // R12: a waiting command keeps its contents until the engine takes it
   p_slot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(op) && $stable(ptr)));

endmodule

// File: rtl/cmdlist_exec_timer.sv
module cmdlist_exec_timer #(
   parameter int EXEC_LAT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int CW = $clog2(EXEC_LAT + 1);

   logic [CW-1:0] cnt;

   assign done = run && (cnt == CW'(EXEC_LAT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end

   // R3: the execute window lasts exactly EXEC_LAT cycles
   p_exec_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !done) |=> run);

endmodule

// File: rtl/cmdlist_stats.sv
module cmdlist_stats #(
   parameter int NUM_CNT = 2,
   parameter int CNT_W   = 32,
   parameter int IDX_W   = $clog2(NUM_CNT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_blk,
   input  logic             inc_susp,
   input  logic             clr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data
);

   logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      logic             bump;
      logic [CNT_W-1:0] c_q;
      if (i == 0) begin : g_blk
         assign bump = inc_blk;
      end else if (i == 1) begin : g_susp
         assign bump = inc_susp;
      end else begin : g_spare
         assign bump = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    c_q <= '0;
         else if (clr)  c_q <= '0;
         else if (bump) c_q <= c_q + 1'b1;
      end
      assign cnt[i] = c_q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = 32'(cnt[i]);
      end
   end

   // R11: a clear leaves the block counter at zero
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt[0] == '0));

endmodule

// File: rtl/cmdlist_walker.sv
module cmdlist_walker
   import cmdlist_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int EXEC_LAT = 4,
   parameter int NUM_CNT  = 2,
   parameter int CNT_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_idle_mode,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [3:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_ptr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [3:0]        mem_req_be,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_rdata,
   output logic              irq_done,
   output logic              irq_notactive,
   output logic [1:0]        cu_state
);

   localparam int IDX_W = $clog2(NUM_CNT + 1);

   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (EXEC_LAT >= 1) else $error("EXEC_LAT must be at least 1");
      assert (NUM_CNT >= 2) else $error("NUM_CNT must be at least 2");
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("CNT_W out of range");
   end

   phase_e            phase;
   cu_state_e         cu_st;
   logic [ADDR_W-1:0] base_r, stats_r, cur_off, next_off, link_q;
   logic [31:0]       hdr0;
   logic [IDX_W-1:0]  dmp_idx;
   logic              dmp_clr;
   logic              irq_done_q, irq_na_q;

   logic              slot_full;
   logic [3:0]        slot_op;
   logic [ADDR_W-1:0] slot_ptr;
   logic              slot_take;
   logic              exec_done;
   logic              wb_ack, dmp_ack, dmp_last;
   logic              inc_blk, inc_susp, cnt_clr;
   logic [31:0]       cnt_rd;

   assign slot_take = (phase == PH_WAIT);
   assign wb_ack    = (phase == PH_WB_RSP)  && mem_rsp_valid;
   assign dmp_ack   = (phase == PH_DMP_RSP) && mem_rsp_valid;
   assign dmp_last  = (dmp_idx == IDX_W'(NUM_CNT));
   assign inc_blk   = wb_ack;
   assign inc_susp  = wb_ack && hdr0[HDR_SUSP];
   assign cnt_clr   = dmp_ack && dmp_last && dmp_clr;

   cmdlist_cmd_slot #(.PTR_W(ADDR_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (cmd_valid),
      .in_ready (cmd_ready),
      .in_op    (cmd_op),
      .in_ptr   (cmd_ptr),
      .take     (slot_take),
      .full     (slot_full),
      .op       (slot_op),
      .ptr      (slot_ptr)
   );

   cmdlist_exec_timer #(.EXEC_LAT(EXEC_LAT)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (phase == PH_EXEC),
      .done  (exec_done)
   );

   cmdlist_stats #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_blk  (inc_blk),
      .inc_susp (inc_susp),
      .clr      (cnt_clr),
      .rd_idx   (dmp_idx),
      .rd_data  (cnt_rd)
   );

   // memory request drive, one outstanding access at a time
   always_comb begin
      mem_req_valid = 1'b0;
      mem_req_we    = 1'b0;
      mem_req_be    = 4'hF;
      mem_req_addr  = base_r + cur_off;
      mem_req_wdata = '0;
      unique case (phase)
         PH_RD0_REQ: mem_req_valid = 1'b1;
         PH_RD1_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = base_r + cur_off + ADDR_W'(4);
         end
         PH_WB_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_be    = BE_STATUS;
            mem_req_wdata = hdr0 | WB_FLAGS;
         end
         PH_RSM_REQ: mem_req_valid = 1'b1;
         PH_DMP_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = stats_r + ADDR_W'({dmp_idx, 2'b00});
            mem_req_wdata = dmp_last ? (dmp_clr ? MARK_DUMP_CLR : MARK_DUMP) : cnt_rd;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_WAIT;
         cu_st      <= CU_IDLE;
         base_r     <= '0;
         stats_r    <= '0;
         cur_off    <= '0;
         next_off   <= '0;
         link_q     <= '0;
         hdr0       <= '0;
         dmp_idx    <= '0;
         dmp_clr    <= 1'b0;
         irq_done_q <= 1'b0;
         irq_na_q   <= 1'b0;
      end else begin
         irq_done_q <= 1'b0;
         irq_na_q   <= 1'b0;
         unique case (phase)
            PH_WAIT: if (slot_full) begin
               case (slot_op)
                  OP_START: if (cu_st == CU_IDLE || cu_st == CU_SUSP) begin
                     cur_off <= slot_ptr;
                     cu_st   <= CU_ACTIVE;
                     phase   <= PH_RD0_REQ;
                  end
                  OP_RESUME:   phase   <= PH_RSM_REQ;
                  OP_LD_BASE:  base_r  <= slot_ptr;
                  OP_LD_STATS: stats_r <= slot_ptr;
                  OP_DUMP, OP_DUMP_CLR: begin
                     dmp_idx <= '0;
                     dmp_clr <= (slot_op == OP_DUMP_CLR);
                     phase   <= PH_DMP_REQ;
                  end
                  default: ;
               endcase
            end
            PH_RD0_REQ: if (mem_req_ready) phase <= PH_RD0_RSP;
            PH_RD0_RSP: if (mem_rsp_valid) begin
               hdr0  <= mem_rsp_rdata;
               phase <= PH_RD1_REQ;
            end
            PH_RD1_REQ: if (mem_req_ready) phase <= PH_RD1_RSP;
            PH_RD1_RSP: if (mem_rsp_valid) begin
               link_q <= mem_rsp_rdata[ADDR_W-1:0];
               phase  <= PH_EXEC;
            end
            PH_EXEC:   if (exec_done) phase <= PH_WB_REQ;
            PH_WB_REQ: if (mem_req_ready) phase <= PH_WB_RSP;
            PH_WB_RSP: if (mem_rsp_valid) begin
               irq_done_q <= hdr0[HDR_IRQ];
               if (hdr0[HDR_SUSP]) begin
                  cu_st    <= CU_SUSP;
                  next_off <= link_q;
                  irq_na_q <= hdr0[HDR_IRQ] & ~cfg_idle_mode;
                  phase    <= PH_WAIT;
               end else if (hdr0[HDR_EL]) begin
                  cu_st    <= CU_IDLE;
                  irq_na_q <= hdr0[HDR_IRQ];
                  phase    <= PH_WAIT;
               end else begin
                  cur_off <= link_q;
                  phase   <= PH_RD0_REQ;
               end
            end
            PH_RSM_REQ: if (mem_req_ready) phase <= PH_RSM_RSP;
            PH_RSM_RSP: if (mem_rsp_valid) begin
               if (mem_rsp_rdata[HDR_SUSP]) begin
                  phase <= PH_WAIT;
               end else begin
                  cu_st <= CU_ACTIVE;
                  if (mem_rsp_rdata[HDR_EL]) begin
                     phase <= PH_WAIT;
                  end else begin
                     cur_off <= next_off;
                     phase   <= PH_RD0_REQ;
                  end
               end
            end
            PH_DMP_REQ: if (mem_req_ready) phase <= PH_DMP_RSP;
            PH_DMP_RSP: if (mem_rsp_valid) begin
               if (dmp_last) phase <= PH_WAIT;
               else begin
                  dmp_idx <= dmp_idx + 1'b1;
                  phase   <= PH_DMP_REQ;
               end
            end
            default: phase <= PH_WAIT;
         endcase
      end
   end

   assign irq_done      = irq_done_q;
   assign irq_notactive = irq_na_q;
   assign cu_state      = cu_st;

   // R3: a stalled request holds its address and direction
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

   // R4: a partial write always carries the complete and ok flags
   p_wb_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we && mem_req_be == BE_STATUS) |->
         (mem_req_wdata[15] && mem_req_wdata[13]));

   // R5: the completion interrupt lasts one cycle
   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);

   // R7: a not-active interrupt never coincides with the active state
   p_na_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_notactive |-> (cu_state != CU_ACTIVE));

   // R12: while a chain is walked the engine issues no command-slot take
   p_walk_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && slot_full) |=> slot_full);

endmodule

// File: tb/test_cmdlist_walker.sv
module test_cmdlist_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_idle_mode = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_op = '0;
   logic [31:0] cmd_ptr = '0;
   logic        mem_req_valid, mem_req_we;
   logic        mem_req_ready = 1'b0;
   logic [3:0]  mem_req_be;
   logic [31:0] mem_req_addr, mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_rdata = '0;
   logic        irq_done, irq_notactive;
   logic [1:0]  cu_state;

   always #4 clk = ~clk;

   cmdlist_walker i_cmdlist_walker (
      .clk(clk), .rst_n(rst_n), .cfg_idle_mode(cfg_idle_mode),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ptr(cmd_ptr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
      .mem_req_be(mem_req_be), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .irq_done(irq_done), .irq_notactive(irq_notactive), .cu_state(cu_state)
   );

   // memory model with host side port and a stalling ready
   logic [31:0] mem [0:255];
   logic        h_we = 1'b0;
   logic [7:0]  h_idx = '0;
   logic [31:0] h_data = '0;
   int          cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_req_ready <= (cyc % 3) != 0;
      mem_rsp_valid <= 1'b0;
      if (h_we) mem[h_idx] <= h_data;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_rdata <= mem[mem_req_addr[9:2]];
         if (mem_req_we)
            for (int b = 0; b < 4; b++)
               if (mem_req_be[b]) mem[mem_req_addr[9:2]][8*b +: 8] <= mem_req_wdata[8*b +: 8];
      end
   end

   // scoreboard
   int checks = 0;
   int errors = 0;
   int req_cnt = 0;
   int n_done = 0;
   int n_na = 0;
   logic [67:0] exp_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_done) n_done++;
         if (irq_notactive) n_na++;
         if (mem_req_valid && mem_req_ready) begin
            req_cnt++;
            if (mem_req_we) begin
               checks++;
               if (exp_q.size() == 0) begin
                  errors++;
                  $display("FAIL R3/R9 unexpected write: actual addr 0x%08h data 0x%08h, expected none",
                           mem_req_addr, mem_req_wdata);
               end else begin
                  logic [67:0] e;
                  e = exp_q.pop_front();
                  if ({mem_req_addr, mem_req_be, mem_req_wdata} !== e) begin
                     errors++;
                     $display("FAIL R4/R8/R11 write stream: actual %h/%h/%h expected %h/%h/%h",
                              mem_req_addr, mem_req_be, mem_req_wdata, e[67:36], e[35:32], e[31:0]);
                  end
               end
            end
         end
      end
   end

   task automatic expect_wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
      exp_q.push_back({a, be, d});
   endtask

   task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_idx = a[9:2]; h_data = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic send(input logic [3:0] op, input logic [31:0] p);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_ptr = p;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic settle();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual run still going, expected end");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int r0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 state", 32'(cu_state), 32'd0);
      check("R1 req", 32'(mem_req_valid), 32'd0);
      check("R1 irq", 32'({irq_done, irq_notactive}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready", 32'(cmd_ready), 32'd1);

      // chain A -> B, base 0x100
      host_wr(32'h100, 32'h2001_0012); host_wr(32'h104, 32'h20);
      host_wr(32'h120, 32'hA002_0000); host_wr(32'h124, 32'h999);
      send(4'd6, 32'h100);                                   // R10 load base
      expect_wr(32'h100, 4'b0011, 32'h2001_A012);
      expect_wr(32'h120, 4'b0011, 32'hA002_A000);            // R8 base+link
      send(4'd1, 32'h0);
      settle();
      check("R7 idle", 32'(cu_state), 32'd0);
      check("R5 done count", n_done, 2);
      check("R7 na count", n_na, 1);
      check("R4 header upper kept", mem[8'h40], 32'h2001_A012);

      // suspend in not-active mode, then gated resume
      host_wr(32'h140, 32'h6003_0000); host_wr(32'h144, 32'h60);
      host_wr(32'h160, 32'h8004_0000); host_wr(32'h164, 32'h0);
      expect_wr(32'h140, 4'b0011, 32'h6003_A000);
      send(4'd1, 32'h40);
      settle();
      check("R6 suspended", 32'(cu_state), 32'd1);
      check("R5 done count", n_done, 3);
      check("R6 na on suspend", n_na, 2);
      r0 = req_cnt;
      send(4'd2, 32'h0);
      settle();
      check("R9 still suspended", 32'(cu_state), 32'd1);
      check("R9 single reread", req_cnt - r0, 1);
      host_wr(32'h140, 32'h2003_A000);
      expect_wr(32'h160, 4'b0011, 32'h8004_A000);
      send(4'd2, 32'h0);
      settle();
      check("R9 resumed to idle", 32'(cu_state), 32'd0);
      check("R5 no irq without flag", n_done, 3);

      // suspend in command-idle mode, then start from suspended
      cfg_idle_mode = 1'b1;
      host_wr(32'h180, 32'h6005_0000); host_wr(32'h184, 32'hA0);
      expect_wr(32'h180, 4'b0011, 32'h6005_A000);
      send(4'd1, 32'h80);
      settle();
      check("R6 suspended idle mode", 32'(cu_state), 32'd1);
      check("R6 na suppressed", n_na, 2);
      host_wr(32'h1C0, 32'hA006_0000); host_wr(32'h1C4, 32'h0);
      expect_wr(32'h1C0, 4'b0011, 32'hA006_A000);
      send(4'd1, 32'hC0);                                    // R2 start from suspended
      settle();
      check("R2 start from suspended", 32'(cu_state), 32'd0);
      check("R7 na in idle mode", n_na, 3);

      // statistics: 6 blocks, 2 suspensions
      send(4'd4, 32'h300);
      expect_wr(32'h300, 4'hF, 32'd6); expect_wr(32'h304, 4'hF, 32'd2);
      expect_wr(32'h308, 4'hF, 32'h0000_A005);
      send(4'd5, 32'h0);
      settle();
      expect_wr(32'h300, 4'hF, 32'd6); expect_wr(32'h304, 4'hF, 32'd2);
      expect_wr(32'h308, 4'hF, 32'h0000_A007);
      send(4'd7, 32'h0);
      settle();
      check("R11 mark in memory", mem[8'hC2], 32'h0000_A007);
      expect_wr(32'h300, 4'hF, 32'd0); expect_wr(32'h304, 4'hF, 32'd0);
      expect_wr(32'h308, 4'hF, 32'h0000_A005);
      send(4'd5, 32'h0);
      settle();

      // R12 dump issued during a walk runs after it
      expect_wr(32'h100, 4'b0011, 32'h2001_A012);
      expect_wr(32'h120, 4'b0011, 32'hA002_A000);
      expect_wr(32'h300, 4'hF, 32'd2); expect_wr(32'h304, 4'hF, 32'd0);
      expect_wr(32'h308, 4'hF, 32'h0000_A005);
      send(4'd1, 32'h0);
      send(4'd5, 32'h0);
      repeat (3) @(negedge clk);
      check("R12 slot held", 32'(cmd_ready), 32'd0);
      settle();
      check("R12 idle after", 32'(cu_state), 32'd0);

      // both flags: suspend wins, then parked active refuses start
      host_wr(32'h200, 32'hC007_0000); host_wr(32'h204, 32'h0);
      expect_wr(32'h200, 4'b0011, 32'hC007_A000);
      send(4'd1, 32'h100);
      settle();
      check("R6 suspend before end", 32'(cu_state), 32'd1);
      host_wr(32'h200, 32'h8007_A000);
      r0 = req_cnt;
      send(4'd2, 32'h0);
      settle();
      check("R9 parked active", 32'(cu_state), 32'd2);
      check("R9 parked one read", req_cnt - r0, 1);
      r0 = req_cnt;
      send(4'd1, 32'h0);
      settle();
      check("R2 start ignored state", 32'(cu_state), 32'd2);
      check("R2 start ignored access", req_cnt - r0, 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule